// File: doc/BRIEF.md
# Power-Good Interrupt and Status Logic

This block watches the output of one or more regulators and reports whether each output is currently valid. For every channel it takes an undervoltage comparator, an overvoltage comparator and the channel's enable. A shared mode bit chooses how validity is judged. In one mode an enabled output is valid whenever it is not under voltage. In the other mode it is valid only when it is neither under nor over voltage. The live validity of each channel is driven onto a status output that never latches.

Each time a channel's validity changes, in either direction, the block sets that channel's sticky power-good flag. Each direction has its own mask, so software can ask to hear only about outputs that become good, only about outputs that become bad, or about both. A flag stays set until software writes one to its clear bit. A single interrupt request line combines every power-good flag with any other sticky flags fed in from neighbouring logic, such as short-circuit events.

Top module: `pwrgood_irq`

## Requirements
- R1: Each `pg_stat` bit shows the channel's present validity (1 = valid) in the same cycle as its inputs, without latching. In window mode (`win_mode` = 1) a channel is valid when it is enabled, `uv_cmp` is 0 and `ov_cmp` is 0.
- R2: In undervoltage-only mode (`win_mode` = 0), `ov_cmp` has no effect on `pg_stat` or on `pg_flag`.
- R3: A change of a channel's validity from 0 to 1 sets its `pg_flag` bit at the next rising clock edge, unless its `mask_rise` bit is 1.
- R4: A change of a channel's validity from 1 to 0 sets its `pg_flag` bit at the next rising clock edge, unless its `mask_fall` bit is 1.
- R5: A set `pg_flag` bit stays set until a clock edge at which its `flag_clr` bit is 1. Then it returns to 0, provided no unmasked edge occurs at that edge. A 0 on `flag_clr` has no effect.
- R6: If an unmasked validity edge and a clear of the same channel fall on the same clock edge, the flag stays set.
- R7: A disabled channel (`reg_en` = 0) has validity 0. Disabling a valid channel sets the flag through the falling-edge rule. Disabling an already invalid channel sets nothing.
- R8: Each validity change is counted once. Validity that stays constant after a clear does not set the flag again.
- R9: `irq_req` is 1 exactly when any `pg_flag` bit or any `ext_flags` bit is 1.
- R10: After the asynchronous active-low reset, all `pg_flag` bits and the remembered validity are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_mode | input | 1 | 1 = window validity, 0 = undervoltage-only validity |
| reg_en | input | N_CH | Regulator enable per channel |
| uv_cmp | input | N_CH | Undervoltage comparator per channel (1 = under) |
| ov_cmp | input | N_CH | Overvoltage comparator per channel (1 = over) |
| mask_rise | input | N_CH | Suppresses the flag on an invalid-to-valid change |
| mask_fall | input | N_CH | Suppresses the flag on a valid-to-invalid change |
| flag_clr | input | N_CH | Write-one-to-clear strobe per flag |
| ext_flags | input | N_EXT | Other sticky flags merged into the request |
| pg_stat | output | N_CH | Live validity per channel |
| pg_flag | output | N_CH | Sticky power-good flag per channel |
| irq_req | output | 1 | Interrupt request |

## Verification
The comparator patterns cover every combination of under, over and enable in both modes. Toggling the overvoltage input in undervoltage-only mode shows that the mode bit really removes that comparator. Rising and falling validity edges are each driven with their own mask set and with it clear. This separates the two masks and shows that one flag serves both directions. A clear that lands on the same edge as a new transition, and a disable from both the valid and the invalid state, distinguish the clear priority and the rule that a disable alone creates no edge. A second channel and the external flag input are driven on their own, which shows that channels stay independent and that the request combines all sources.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic {
    PG_MODE_UV_ONLY = 1'b0,
    PG_MODE_WINDOW  = 1'b1
  } pg_mode_e;

  // Validity of one channel from its comparators and enable.
  function automatic logic pg_judge(input logic en, input logic uv,
                                    input logic ov, input pg_mode_e mode);
    logic over_bad;
    over_bad = (mode == PG_MODE_WINDOW) ? ov : 1'b0;
    return en & ~uv & ~over_bad;
  endfunction

  // Next value of a sticky flag: an unmasked event wins over a clear.
  function automatic logic pg_flag_next(input logic cur, input logic clr,
                                        input logic set_evt);
    return (cur & ~clr) | set_evt;
  endfunction
endpackage

// File: rtl/pg_valid_eval.sv
module pg_valid_eval
  import pg_pkg::*;
#(
  parameter int N_CH = 2
) (
  input  logic            win_mode,
  input  logic [N_CH-1:0] reg_en,
  input  logic [N_CH-1:0] uv_cmp,
  input  logic [N_CH-1:0] ov_cmp,
  output logic [N_CH-1:0] valid
);
  pg_mode_e mode;
  assign mode = pg_mode_e'(win_mode);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    always_comb valid[g] = pg_judge(reg_en[g], uv_cmp[g], ov_cmp[g], mode);
  end
endmodule

// File: rtl/pg_edge_det.sv
module pg_edge_det #(
  parameter int N_CH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] valid,
  output logic [N_CH-1:0] rise_evt,
  output logic [N_CH-1:0] fall_evt
);
  logic [N_CH-1:0] valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid;
  end

  assign rise_evt = valid & ~valid_q;
  assign fall_evt = ~valid & valid_q;
endmodule

// File: rtl/pg_flag_bank.sv
module pg_flag_bank
  import pg_pkg::*;
#(
  parameter int N_CH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] rise_evt,
  input  logic [N_CH-1:0] fall_evt,
  input  logic [N_CH-1:0] mask_rise,
  input  logic [N_CH-1:0] mask_fall,
  input  logic [N_CH-1:0] flag_clr,
  output logic [N_CH-1:0] set_evt,
  output logic [N_CH-1:0] flag
);
  assign set_evt = (rise_evt & ~mask_rise) | (fall_evt & ~mask_fall);

  for (genvar g = 0; g < N_CH; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag[g] <= 1'b0;
      else        flag[g] <= pg_flag_next(flag[g], flag_clr[g], set_evt[g]);
    end
  end
endmodule

// File: rtl/pwrgood_irq.sv
module pwrgood_irq #(
  parameter int N_CH  = 2,
  parameter int N_EXT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_mode,
  input  logic [N_CH-1:0]  reg_en,
  input  logic [N_CH-1:0]  uv_cmp,
  input  logic [N_CH-1:0]  ov_cmp,
  input  logic [N_CH-1:0]  mask_rise,
  input  logic [N_CH-1:0]  mask_fall,
  input  logic [N_CH-1:0]  flag_clr,
  input  logic [N_EXT-1:0] ext_flags,
  output logic [N_CH-1:0]  pg_stat,
  output logic [N_CH-1:0]  pg_flag,
  output logic             irq_req
);
  logic [N_CH-1:0] valid_now;
  logic [N_CH-1:0] rise_evt;
  logic [N_CH-1:0] fall_evt;
  logic [N_CH-1:0] set_evt;

  pg_valid_eval #(.N_CH(N_CH)) u_eval (
    .win_mode (win_mode),
    .reg_en   (reg_en),
    .uv_cmp   (uv_cmp),
    .ov_cmp   (ov_cmp),
    .valid    (valid_now)
  );

  pg_edge_det #(.N_CH(N_CH)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (valid_now),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  pg_flag_bank #(.N_CH(N_CH)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .mask_rise (mask_rise),
    .mask_fall (mask_fall),
    .flag_clr  (flag_clr),
    .set_evt   (set_evt),
    .flag      (pg_flag)
  );

  assign pg_stat = valid_now;
  assign irq_req = (|pg_flag) | (|ext_flags);
endmodule

// File: rtl/pwrgood_irq_chk.sv
module pwrgood_irq_chk #(
  parameter int N_CH  = 2,
  parameter int N_EXT = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_CH-1:0]  reg_en,
  input logic [N_CH-1:0]  mask_rise,
  input logic [N_CH-1:0]  mask_fall,
  input logic [N_CH-1:0]  flag_clr,
  input logic [N_EXT-1:0] ext_flags,
  input logic [N_CH-1:0]  pg_stat,
  input logic [N_CH-1:0]  pg_flag,
  input logic             irq_req,
  input logic [N_CH-1:0]  rise_evt,
  input logic [N_CH-1:0]  fall_evt
);
  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    assert_rise_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_evt[g] && !mask_rise[g]) |=> pg_flag[g]);
    assert_fall_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_evt[g] && !mask_fall[g]) |=> pg_flag[g]);
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_flag[g] && !flag_clr[g]) |=> pg_flag[g]);
    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pg_flag[g] && !rise_evt[g] && !fall_evt[g]) |=> !pg_flag[g]);
    assert_clear_collide_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[g] && fall_evt[g] && !mask_fall[g]) |=> pg_flag[g]);
    assert_disabled_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_en[g] |-> !pg_stat[g]);
    assert_edge_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rise_evt[g] |=> !rise_evt[g]);
  end

  assert_ext_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|ext_flags) |-> irq_req);
  assert_flag_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|pg_flag) |-> irq_req);
endmodule

bind pwrgood_irq pwrgood_irq_chk #(.N_CH(N_CH), .N_EXT(N_EXT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_en    (reg_en),
  .mask_rise (mask_rise),
  .mask_fall (mask_fall),
  .flag_clr  (flag_clr),
  .ext_flags (ext_flags),
  .pg_stat   (pg_stat),
  .pg_flag   (pg_flag),
  .irq_req   (irq_req),
  .rise_evt  (rise_evt),
  .fall_evt  (fall_evt)
);

// File: tb/pwrgood_irq_bench.sv
module pwrgood_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH  = 2;
  localparam int N_EXT = 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             win_mode;
  logic [N_CH-1:0]  reg_en, uv_cmp, ov_cmp, mask_rise, mask_fall, flag_clr;
  logic [N_EXT-1:0] ext_flags;
  logic [N_CH-1:0]  pg_stat, pg_flag;
  logic             irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrgood_irq #(.N_CH(N_CH), .N_EXT(N_EXT)) u_pwrgood_irq (
    .clk(clk), .rst_n(rst_n), .win_mode(win_mode), .reg_en(reg_en),
    .uv_cmp(uv_cmp), .ov_cmp(ov_cmp), .mask_rise(mask_rise),
    .mask_fall(mask_fall), .flag_clr(flag_clr), .ext_flags(ext_flags),
    .pg_stat(pg_stat), .pg_flag(pg_flag), .irq_req(irq_req)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_flags(input logic [N_CH-1:0] which);
    tick(); flag_clr = which;
    tick(); flag_clr = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; win_mode = 1'b1; reg_en = '0; uv_cmp = '0; ov_cmp = '0;
    mask_rise = '0; mask_fall = '0; flag_clr = '0; ext_flags = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R10", "flags after reset", 32'(pg_flag), 0);
    check("R10", "irq after reset", 32'(irq_req), 0);
    check("R1", "status disabled", 32'(pg_stat), 0);
  endtask

  task automatic t_status();
    mask_rise = '1; mask_fall = '1;
    tick(); reg_en[0] = 1'b1; #1;
    check("R1", "window, no faults", 32'(pg_stat[0]), 1);
    tick(); ov_cmp[0] = 1'b1; #1;
    check("R1", "window, over", 32'(pg_stat[0]), 0);
    tick(); win_mode = 1'b0; #1;
    check("R2", "uv-only ignores over", 32'(pg_stat[0]), 1);
    tick(); uv_cmp[0] = 1'b1; #1;
    check("R1", "uv-only, under", 32'(pg_stat[0]), 0);
    tick();
    check("R3", "masked edges leave flag", 32'(pg_flag[0]), 0);
    win_mode = 1'b1; ov_cmp[0] = 1'b0;
    tick(); mask_rise = '0; mask_fall = '0;
  endtask

  task automatic t_rise_and_sticky();
    tick(); uv_cmp[0] = 1'b0;
    tick();
    check("R3", "rising edge sets flag", 32'(pg_flag), 32'b01);
    check("R9", "irq from flag", 32'(irq_req), 1);
    repeat (3) tick();
    check("R5", "flag held", 32'(pg_flag[0]), 1);
    clear_flags(2'b01);
    check("R5", "flag cleared", 32'(pg_flag[0]), 0);
    check("R9", "irq drops", 32'(irq_req), 0);
    repeat (3) tick();
    check("R8", "steady valid no reset", 32'(pg_flag[0]), 0);
  endtask

  task automatic t_fall();
    tick(); uv_cmp[0] = 1'b1;
    tick();
    check("R4", "falling edge sets flag", 32'(pg_flag[0]), 1);
    clear_flags(2'b01);
    check("R5", "clear after fall", 32'(pg_flag[0]), 0);
  endtask

  task automatic t_masks();
    tick(); mask_rise[0] = 1'b1; uv_cmp[0] = 1'b0;
    tick();
    check("R3", "rise mask blocks", 32'(pg_flag[0]), 0);
    mask_rise[0] = 1'b0; mask_fall[0] = 1'b1; uv_cmp[0] = 1'b1;
    tick();
    check("R4", "fall mask blocks", 32'(pg_flag[0]), 0);
    mask_fall[0] = 1'b0;
  endtask

  task automatic t_collide();
    tick(); uv_cmp[0] = 1'b0;
    tick();
    check("R3", "rise before collide", 32'(pg_flag[0]), 1);
    uv_cmp[0] = 1'b1; flag_clr[0] = 1'b1;
    tick(); flag_clr = '0;
    check("R6", "edge wins over clear", 32'(pg_flag[0]), 1);
    clear_flags(2'b01);
    check("R5", "clear after collide", 32'(pg_flag[0]), 0);
  endtask

  task automatic t_disable();
    tick(); reg_en[0] = 1'b0;
    tick();
    check("R7", "disable while invalid", 32'(pg_flag[0]), 0);
    uv_cmp[0] = 1'b0; reg_en[0] = 1'b1;
    tick();
    check("R3", "enable makes valid", 32'(pg_flag[0]), 1);
    clear_flags(2'b01);
    tick(); reg_en[0] = 1'b0; #1;
    check("R7", "disabled is invalid", 32'(pg_stat[0]), 0);
    tick();
    check("R7", "disable while valid", 32'(pg_flag[0]), 1);
    clear_flags(2'b01);
  endtask

  task automatic t_ext_and_ch1();
    tick(); ext_flags = 1'b1; #1;
    check("R9", "irq from ext", 32'(irq_req), 1);
    check("R9", "ext leaves flags", 32'(pg_flag), 0);
    tick(); ext_flags = 1'b0; #1;
    check("R9", "irq idle", 32'(irq_req), 0);
    tick(); reg_en[1] = 1'b1;
    tick();
    check("R3", "channel 1 alone", 32'(pg_flag), 32'b10);
    clear_flags(2'b10);
    tick(); win_mode = 1'b0; ov_cmp[1] = 1'b1;
    tick();
    check("R2", "over ignored in uv-only stat", 32'(pg_stat[1]), 1);
    check("R2", "over ignored in uv-only flag", 32'(pg_flag[1]), 0);
  endtask

  initial begin
    t_reset();
    t_status();
    t_rise_and_sticky();
    t_fall();
    t_masks();
    t_collide();
    t_disable();
    t_ext_and_ch1();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule